// File: doc/BRIEF.md
# Adaptive Scan Compression Wrapper

This block sits between a narrow set of external scan pins and a larger number of internal scan chains. On the load side, each internal chain gets its serial input from one of the external scan inputs. A per-chain select field in a configuration word picks that input. Tester software may rewrite the configuration word between any two shift cycles of a pattern, so a chain can change its source input partway through a load.

On the unload side, an XOR compactor folds the chain tails onto a smaller set of external scan outputs. Every chain drives exactly two outputs, and no two chains share the same pair of outputs. If one chain carries an unknown value, every other chain can still be seen on at least one output that the unknown chain does not reach.

The wrapper holds no state. It uses neither a clock nor a reset, so it changes nothing about how the chains are clocked or extracted.

Top module: `adaptive_scan_codec`

## Requirements
- R1: Chain c takes its serial input from the external scan input whose index equals the select field held in cfg bits [c*SELW +: SELW], where SELW = ceil(log2(N_IN)) with a minimum of 1.
- R2: A select field whose value is N_IN or larger routes scan input 0 to that chain.
- R3: All chains whose fields resolve to the same scan input carry identical serial data.
- R4: A new configuration word reroutes the chains in the same cycle it is applied, with no cycle of latency. Successive shift cycles of one pattern can therefore use different routings.
- R5: The block holds no state. Every output is a pure function of the present scan_in, cfg and chain_so values.
- R6: Scan output o is the XOR of the tails of every chain mapped to it. Chain c maps to output a = c mod N_OUT and to output (a + 1 + c div N_OUT) mod N_OUT.
- R7: Flipping the tail of any single chain, with all other inputs held, toggles exactly two scan outputs.
- R8: No two chains reach the same pair of outputs. For any chain k, every other chain toggles at least one output that chain k does not reach.
- R9: When all chain tails are 0, all scan outputs are 0.
- R10: The scan outputs always have even parity, because each chain reaches an even number of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| scan_in | input | N_IN | External serial scan data inputs |
| cfg | input | N_CHAIN*SELW | Per-chain source select fields; chain c uses bits [c*SELW +: SELW] |
| chain_si | output | N_CHAIN | Serial input driven into the head of each internal chain |
| chain_so | input | N_CHAIN | Serial output taken from the tail of each internal chain |
| scan_out | output | N_OUT | Compacted external scan outputs |

## Verification
The block is purely combinational, so a fault shows at the ports in the same cycle the stimulus is applied. A decoder that misreads a select field drives the wrong value into a chain head. An out-of-range code that is not forced to input 0 shows up as a mismatch against scan input 0. A wrong entry in the compactor map shows as an odd number of toggled outputs, or as the wrong pair of toggled outputs, when a single chain tail is flipped. The single-chain flip masks also expose any two chains that share an output pair, because that pair would then leave one chain with no output of its own.

// File: rtl/scan_cmp_pkg.sv
package scan_cmp_pkg;

   // Width of one per-chain select field
   function automatic int sel_width(input int n_in);
      return (n_in > 1) ? $clog2(n_in) : 1;
   endfunction

   // First output reached by chain c
   function automatic int out_first(input int c, input int n_out);
      return c % n_out;
   endfunction

   // Second output reached by chain c: offset grows with each wrap over the outputs
   function automatic int out_second(input int c, input int n_out);
      return ((c % n_out) + 1 + (c / n_out)) % n_out;
   endfunction

   // Largest number of chains that still get distinct output pairs
   function automatic int max_chains(input int n_out);
      return n_out * ((n_out - 1) / 2);
   endfunction

endpackage

// File: rtl/scan_cmp_load.sv
module scan_cmp_load #(
   parameter int N_IN    = 3,
   parameter int N_CHAIN = 8,
   parameter int SELW    = 2
) (
   input  logic [N_IN-1:0]         scan_in,
   input  logic [N_CHAIN*SELW-1:0] cfg,
   output logic [N_CHAIN-1:0]      chain_si
);

   generate
      if (N_IN == 1) begin : g_single
         // One input only: every chain shares it, select fields are don't-care
         logic unused_cfg;
         assign unused_cfg = ^cfg;
         assign chain_si   = {N_CHAIN{scan_in[0]}};
      end else begin : g_mux
         for (genvar c = 0; c < N_CHAIN; c++) begin : g_chain
            logic [SELW-1:0] code;
            logic            head;
            assign code = cfg[c*SELW +: SELW];
            always_comb begin
               head = scan_in[0];               // default covers out-of-range codes
               for (int i = 1; i < N_IN; i++) begin
                  if (int'(code) == i) head = scan_in[i];
               end
            end
            assign chain_si[c] = head;
         end
      end
   endgenerate

endmodule

// File: rtl/scan_cmp_unload.sv
module scan_cmp_unload #(
   parameter int N_CHAIN = 8,
   parameter int N_OUT   = 5
) (
   input  logic [N_CHAIN-1:0] chain_so,
   output logic [N_OUT-1:0]   scan_out
);
   import scan_cmp_pkg::*;

   generate
      for (genvar o = 0; o < N_OUT; o++) begin : g_out
         logic acc;
         always_comb begin
            acc = 1'b0;
            for (int c = 0; c < N_CHAIN; c++) begin
               if (out_first(c, N_OUT) == o || out_second(c, N_OUT) == o)
                  acc = acc ^ chain_so[c];
            end
         end
         assign scan_out[o] = acc;
      end
   endgenerate

endmodule

// File: rtl/adaptive_scan_codec.sv
module adaptive_scan_codec #(
   parameter  int N_IN    = 3,
   parameter  int N_CHAIN = 8,
   parameter  int N_OUT   = 5,
   localparam int SELW    = scan_cmp_pkg::sel_width(N_IN)
) (
   input  logic [N_IN-1:0]         scan_in,
   input  logic [N_CHAIN*SELW-1:0] cfg,
   output logic [N_CHAIN-1:0]      chain_si,
   input  logic [N_CHAIN-1:0]      chain_so,
   output logic [N_OUT-1:0]        scan_out
);

   // Elaboration-time parameter checks
   generate
      if (N_IN < 1)   begin : g_bad_in    $error("N_IN must be at least 1");  end
      if (N_OUT < 3)  begin : g_bad_out   $error("N_OUT must be at least 3"); end
      if (N_CHAIN < 1) begin : g_bad_ch   $error("N_CHAIN must be at least 1"); end
      if (N_CHAIN > scan_cmp_pkg::max_chains(N_OUT)) begin : g_bad_pairs
         $error("N_CHAIN exceeds the number of distinct output pairs");
      end
   endgenerate

   scan_cmp_load #(
      .N_IN   (N_IN),
      .N_CHAIN(N_CHAIN),
      .SELW   (SELW)
   ) u_load (
      .scan_in (scan_in),
      .cfg     (cfg),
      .chain_si(chain_si)
   );

   scan_cmp_unload #(
      .N_CHAIN(N_CHAIN),
      .N_OUT  (N_OUT)
   ) u_unload (
      .chain_so(chain_so),
      .scan_out(scan_out)
   );

endmodule

// File: rtl/adaptive_scan_codec_chk.sv
module adaptive_scan_codec_chk #(
   parameter int N_IN    = 3,
   parameter int N_CHAIN = 8,
   parameter int N_OUT   = 5,
   parameter int SELW    = 2
) (
   input logic [N_IN-1:0]         scan_in,
   input logic [N_CHAIN*SELW-1:0] cfg,
   input logic [N_CHAIN-1:0]      chain_si,
   input logic [N_CHAIN-1:0]      chain_so,
   input logic [N_OUT-1:0]        scan_out
);

   function automatic int eff_sel(input int c, input logic [N_CHAIN*SELW-1:0] w);
      int code;
      code = int'(w[c*SELW +: SELW]);
      return (code < N_IN) ? code : 0;
   endfunction

   always_comb begin
      if (!$isunknown({scan_in, cfg, chain_si, chain_so, scan_out})) begin
         // R10: every chain reaches two outputs, so overall parity is even
         a_r10_even_parity: assert (^scan_out == 1'b0)
            else $error("R10 odd parity on scan_out");
         // R9: quiet tails give quiet outputs
         a_r9_idle_zero: assert (chain_so != '0 || scan_out == '0)
            else $error("R9 nonzero scan_out with zero tails");
         // R7: a single active tail lights exactly two outputs
         a_r7_two_outputs: assert ($countones(chain_so) != 1 || $countones(scan_out) == 2)
            else $error("R7 single tail did not reach two outputs");
         for (int c = 0; c < N_CHAIN; c++) begin
            // R2: out-of-range field falls back to input 0
            a_r2_range_default: assert (int'(cfg[c*SELW +: SELW]) < N_IN || chain_si[c] == scan_in[0])
               else $error("R2 out-of-range field not routed to input 0");
            for (int j = c + 1; j < N_CHAIN; j++) begin
               // R3: chains sharing a source carry the same bit
               a_r3_shared_source: assert (eff_sel(c, cfg) != eff_sel(j, cfg) || chain_si[c] == chain_si[j])
                  else $error("R3 chains on one input differ");
            end
         end
      end
   end

endmodule

bind adaptive_scan_codec adaptive_scan_codec_chk #(
   .N_IN   (N_IN),
   .N_CHAIN(N_CHAIN),
   .N_OUT  (N_OUT),
   .SELW   (SELW)
) u_chk (
   .scan_in (scan_in),
   .cfg     (cfg),
   .chain_si(chain_si),
   .chain_so(chain_so),
   .scan_out(scan_out)
);

// File: tb/adaptive_scan_codec_bench.sv
module adaptive_scan_codec_bench;
   localparam int N_IN    = 3;
   localparam int N_CHAIN = 8;
   localparam int N_OUT   = 5;
   localparam int SELW    = 2;
   localparam int CW      = N_CHAIN*SELW;

   typedef struct {
      logic [N_CHAIN-1:0] exp_si;
      logic [N_OUT-1:0]   exp_so;
      string              tag;
   } item_t;

   logic clk = 1'b0;
   logic [N_IN-1:0]    scan_in  = '0;
   logic [CW-1:0]      cfg      = '0;
   logic [N_CHAIN-1:0] chain_so = '0;
   logic [N_CHAIN-1:0] chain_si;
   logic [N_OUT-1:0]   scan_out;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   item_t sb[$];

   always #5 clk = ~clk;

   adaptive_scan_codec u_adaptive_scan_codec (
      .scan_in (scan_in),
      .cfg     (cfg),
      .chain_si(chain_si),
      .chain_so(chain_so),
      .scan_out(scan_out)
   );

   // Expected chain heads per R1/R2
   function automatic logic [N_CHAIN-1:0] model_si(input logic [N_IN-1:0] si, input logic [CW-1:0] w);
      logic [N_CHAIN-1:0] r;
      for (int c = 0; c < N_CHAIN; c++) begin
         int code;
         code = int'(w[c*SELW +: SELW]);
         r[c] = si[(code < N_IN) ? code : 0];
      end
      return r;
   endfunction

   // Expected outputs per R6
   function automatic logic [N_OUT-1:0] model_so(input logic [N_CHAIN-1:0] t);
      logic [N_OUT-1:0] r;
      r = '0;
      for (int c = 0; c < N_CHAIN; c++) begin
         int a, b;
         a = c % N_OUT;
         b = (a + 1 + c / N_OUT) % N_OUT;
         r[a] = r[a] ^ t[c];
         r[b] = r[b] ^ t[c];
      end
      return r;
   endfunction

   function automatic logic [CW-1:0] pack_cfg(input int s0, input int s1, input int s2, input int s3,
                                              input int s4, input int s5, input int s6, input int s7);
      logic [CW-1:0] w;
      w = {SELW'(s7), SELW'(s6), SELW'(s5), SELW'(s4), SELW'(s3), SELW'(s2), SELW'(s1), SELW'(s0)};
      return w;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Driver: apply one vector per cycle and push its expectation
   task automatic drive(input logic [N_IN-1:0] si, input logic [CW-1:0] w,
                        input logic [N_CHAIN-1:0] t, input string tag);
      item_t it;
      @(posedge clk);
      #1;
      scan_in  = si;
      cfg      = w;
      chain_so = t;
      it.exp_si = model_si(si, w);
      it.exp_so = model_so(t);
      it.tag    = tag;
      sb.push_back(it);
   endtask

   // Monitor: compare at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(chain_si == it.exp_si, {it.tag, " heads"}, 32'(chain_si), 32'(it.exp_si));
            check(scan_out == it.exp_so, {it.tag, " outputs"}, 32'(scan_out), 32'(it.exp_so));
            check(^scan_out == 1'b0, "R10 parity", 32'(scan_out), 32'(it.exp_so));
         end
      end
   end

   // Single-tail toggle mask, observed at the ports
   task automatic tail_mask(input int k, output logic [N_OUT-1:0] m);
      @(posedge clk);
      #1;
      scan_in  = '0;
      cfg      = '0;
      chain_so = N_CHAIN'(1) << k;
      @(negedge clk);
      m = scan_out;
   endtask

   logic [N_OUT-1:0] masks [N_CHAIN];

   initial begin
      // R9: idle inputs
      drive('0, '0, '0, "R9 idle");
      // R1: each chain on input c mod 3, several scan_in patterns
      for (int p = 0; p < 8; p++)
         drive(N_IN'(p), pack_cfg(0, 1, 2, 0, 1, 2, 0, 1), '0, "R1 route mod3");
      // R3: all chains share input 2
      drive(3'b100, pack_cfg(2, 2, 2, 2, 2, 2, 2, 2), '0, "R3 shared hi");
      drive(3'b011, pack_cfg(2, 2, 2, 2, 2, 2, 2, 2), '0, "R3 shared lo");
      // R2: out-of-range code 3 falls back to input 0
      drive(3'b001, pack_cfg(3, 3, 1, 3, 2, 3, 3, 3), '0, "R2 oor one");
      drive(3'b110, pack_cfg(3, 3, 1, 3, 2, 3, 3, 3), '0, "R2 oor zero");
      // R4: routing changes each cycle while scan_in holds
      drive(3'b010, pack_cfg(0, 0, 0, 0, 0, 0, 0, 0), '0, "R4 step a");
      drive(3'b010, pack_cfg(1, 1, 1, 1, 0, 0, 0, 0), '0, "R4 step b");
      drive(3'b010, pack_cfg(2, 1, 0, 3, 1, 2, 1, 0), '0, "R4 step c");
      // R6: walking tails
      for (int c = 0; c < N_CHAIN; c++)
         drive('0, '0, N_CHAIN'(1) << c, "R6 walk");
      drive('0, '0, '1, "R6 all ones");
      // R5: mixed random vectors, result depends on current inputs only
      for (int n = 0; n < 40; n++)
         drive(N_IN'($urandom), CW'($urandom), N_CHAIN'($urandom), "R5 random");
      drive('0, '0, '0, "R9 idle again");
      wait (sb.size() == 0);
      @(negedge clk);

      // R7: each single tail toggles exactly two outputs, the mapped pair
      for (int k = 0; k < N_CHAIN; k++) begin
         logic [N_OUT-1:0] m;
         tail_mask(k, m);
         masks[k] = m;
         check($countones(m) == 2, "R7 two outputs", 32'(m), 32'(model_so(N_CHAIN'(1) << k)));
      end
      // R8: distinct pairs, and each other chain keeps an output free of chain k
      for (int k = 0; k < N_CHAIN; k++) begin
         for (int j = 0; j < N_CHAIN; j++) begin
            if (j != k) begin
               check(masks[j] != masks[k], "R8 distinct pair", 32'(masks[j]), 32'(masks[k]));
               check((masks[j] & ~masks[k]) != '0, "R8 observable beside unknown",
                     32'(masks[j] & ~masks[k]), 32'(masks[j]));
            end
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%h expected=%h", 32'(0), 32'(1));
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule